// File: doc/BRIEF.md
# SMM Memory Window Access Controller

This block sits in the memory decode path of a host bridge and decides, for every memory access, whether it goes to DRAM, to the PCI / legacy video side, to an all-ones "hole", or passes through unchanged. It guards three areas used by system management mode. The first is the legacy video-range window at 0x000A0000–0x000BFFFF. The second is a high alias of those same DRAM bytes at 0xFEDA0000–0xFEDBFFFF. The third is a segment of configurable size placed just below the top of low memory.

Two 8-bit control bytes set the routing, and software writes them through a byte-enabled port. The SMRAM byte holds the open, lock and global-enable bits. The extended byte holds the high-alias enable, the top-segment enable and the top-segment size. Setting the lock bit freezes both bytes and closes the open bit until the next reset.

Each access presents an address, a write flag and a flag that marks it as coming from system management mode. The routing answer is purely combinational from the registered control bytes, so it is valid in the same cycle as the access.

Top module: `smm_window_ctl`

## Requirements
- R1: After reset the SMRAM byte reads 0x02 and the extended byte reads 0x38; `cfg_rdata` always shows {extended byte, SMRAM byte}, with SMRAM bits [2:0] fixed at 3'b010 and extended bits [5:3] fixed at 3'b111.
- R2: On a write with `cfg_be[0]` set, SMRAM bits 6 (open), 4 (lock) and 3 (global enable) take the new value. On a write with `cfg_be[1]` set, extended bits 7 (high enable), 2:1 (size) and 0 (segment enable) take the new value. All other bits, and any byte whose enable is clear, keep their value.
- R3: While lock is 1, the open bit is 0 (a write that sets lock and open together leaves open at 0), lock stays 1, and writes change neither byte until reset.
- R4: A non-SMM access to the low window goes to DRAM only when open=1 and high enable=0, and goes to PCI otherwise. A non-SMM access to the high alias goes to DRAM only when open=1 and high enable=1, and passes through otherwise.
- R5: An SMM access with global enable=1 reaches DRAM through the low window when high enable=0, and through the high alias when high enable=1. In every other SMM case the non-SMM rules of R4 apply.
- R6: The segment size is 1 MB for size code 00, 2 MB for 01 and 8 MB for 10. Size code 11, or segment enable=0, gives no segment.
- R7: The segment covers [tolm − size, tolm), and the decision ignores address bits [1:0]. SMM accesses to it go to DRAM. Non-SMM reads of it go to the hole and return 0xFFFFFFFF on `hole_rdata`. Non-SMM writes to it go to the hole with `hole_wdrop`=1.
- R8: An access routed to DRAM through the high alias carries `dram_addr` = address − 0xFED00000. All other accesses carry their own address.
- R9: An address outside every window gets route 0 (pass), with `hole_rdata`=0 and `hole_wdrop`=0.
- R10: A control write changes routing from the next cycle on. An access in the same cycle as the write is decoded with the old bytes.
- R11: Route codes are 0 = pass, 1 = DRAM, 2 = PCI/video, 3 = hole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_be | input | 2 | Byte enables: bit 0 SMRAM byte, bit 1 extended byte |
| cfg_wdata | input | 16 | Write data {extended, SMRAM} |
| cfg_rdata | output | 16 | Current {extended, SMRAM} bytes |
| tolm | input | ADDR_W | Top of low memory (exclusive) |
| acc_addr | input | ADDR_W | Access address |
| acc_smm | input | 1 | Access is from system management mode |
| acc_wr | input | 1 | Access is a write |
| route | output | 2 | Route code (R11) |
| dram_addr | output | ADDR_W | Address presented to DRAM |
| hole_rdata | output | 32 | Read data for hole reads, else 0 |
| hole_wdrop | output | 1 | Write discarded by the hole |

## Verification
A control write and a routed access can land in the same cycle. This is the case where stale and fresh routing could be confused. The bench provokes it by driving a write that opens the window together with a non-SMM access to the high alias. It expects the pass-through answer of the old bytes in that cycle and DRAM routing in the following cycle. The same overlap arises when the lock write itself coincides with later writes. The bench judges this by reading the control bytes back unchanged after every write attempted under lock.

// File: rtl/smm_window_ctl.sv
module smm_window_ctl #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_be,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_wr,
  output logic [1:0]        route,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [31:0]       hole_rdata,
  output logic              hole_wdrop
);
  localparam logic [ADDR_W-1:0] LOW_END   = LOW_BASE + WIN_SIZE;
  localparam logic [ADDR_W-1:0] HIGH_END  = HIGH_BASE + WIN_SIZE;
  localparam logic [ADDR_W-1:0] ALIAS_OFF = HIGH_BASE - LOW_BASE;
  localparam logic [ADDR_W-1:0] MB        = ADDR_W'(1) << 20;
  localparam logic [7:0] SMR_RST = 8'h02, EXT_RST = 8'h38;
  localparam logic [7:0] SMR_WM  = 8'h58, EXT_WM  = 8'h87;
  localparam logic [1:0] RT_PASS = 2'd0, RT_DRAM = 2'd1, RT_PCI = 2'd2, RT_HOLE = 2'd3;

  logic [7:0] smr_q, ext_q, smr_nx, ext_nx;
  wire lock = smr_q[4];
  wire [7:0] smr_wm = lock ? 8'h00 : SMR_WM;
  wire [7:0] ext_wm = lock ? 8'h00 : EXT_WM;

  always_comb begin
    smr_nx = (smr_q & ~smr_wm) | (cfg_wdata[7:0] & smr_wm);
    if (smr_nx[4]) smr_nx[6] = 1'b0;
    ext_nx = (ext_q & ~ext_wm) | (cfg_wdata[15:8] & ext_wm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smr_q <= SMR_RST;
      ext_q <= EXT_RST;
    end else if (cfg_wr) begin
      if (cfg_be[0]) smr_q <= smr_nx;
      if (cfg_be[1]) ext_q <= ext_nx;
    end
  end

  assign cfg_rdata = {ext_q, smr_q};

  wire open_b = smr_q[6];
  wire gen    = smr_q[3];
  wire hien   = ext_q[7];

  logic [ADDR_W-1:0] seg_size;
  always_comb begin
    seg_size = '0;
    if (ext_q[0]) begin
      case (ext_q[2:1])
        2'b00:   seg_size = MB;
        2'b01:   seg_size = MB << 1;
        2'b10:   seg_size = MB << 3;
        default: seg_size = '0;
      endcase
    end
  end

  wire [ADDR_W-1:0] word_addr = {acc_addr[ADDR_W-1:2], 2'b00};
  wire [ADDR_W-1:0] seg_base  = tolm - seg_size;
  wire in_seg  = (seg_size != '0) && (word_addr >= seg_base) && (word_addr < tolm);
  wire in_low  = (acc_addr >= LOW_BASE) && (acc_addr < LOW_END);
  wire in_high = (acc_addr >= HIGH_BASE) && (acc_addr < HIGH_END);

  always_comb begin
    route     = RT_PASS;
    dram_addr = acc_addr;
    if (in_seg) begin
      route = acc_smm ? RT_DRAM : RT_HOLE;
    end else if (in_low) begin
      if ((acc_smm && gen && !hien) || (open_b && !hien)) route = RT_DRAM;
      else                                                route = RT_PCI;
    end else if (in_high) begin
      if ((acc_smm && gen && hien) || (open_b && hien)) begin
        route     = RT_DRAM;
        dram_addr = acc_addr - ALIAS_OFF;
      end
    end
  end

  assign hole_rdata = (route == RT_HOLE && !acc_wr) ? 32'hFFFF_FFFF : 32'h0;
  assign hole_wdrop = (route == RT_HOLE) && acc_wr;
endmodule

// File: rtl/smm_window_chk.sv
module smm_window_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [15:0]       cfg_rdata,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_smm,
  input logic              acc_wr,
  input logic [1:0]        route,
  input logic [31:0]       hole_rdata,
  input logic              hole_wdrop
);
  a_r1_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[2:0] == 3'b010 && cfg_rdata[13:11] == 3'b111);

  a_r3_open_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4] |-> !cfg_rdata[6]);

  a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4] |=> cfg_rdata[4]);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[4] |=> $stable(cfg_rdata));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));

  a_r7_hole_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (route == 2'd3 && !acc_wr) |-> hole_rdata == 32'hFFFF_FFFF);

  a_r7_smm_no_hole: assert property (@(posedge clk) disable iff (!rst_n)
    acc_smm |-> (route != 2'd3 && !hole_wdrop));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    route != 2'd3 |-> (hole_rdata == 32'h0 && !hole_wdrop));

  a_r4_closed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_smm && !cfg_rdata[6] && acc_addr >= 32'h000A_0000 && acc_addr < 32'h000C_0000)
      |-> route == 2'd2);
endmodule

bind smm_window_ctl smm_window_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
  .acc_addr(acc_addr), .acc_smm(acc_smm), .acc_wr(acc_wr), .route(route),
  .hole_rdata(hole_rdata), .hole_wdrop(hole_wdrop)
);

// File: tb/tb_smm_window_ctl.sv
`timescale 1ns/1ps
module tb_smm_window_ctl;
  logic        clk = 0, rst_n = 0;
  logic        cfg_wr = 0;
  logic [1:0]  cfg_be = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic [31:0] tolm = 32'h0800_0000, acc_addr = 0, dram_addr, hole_rdata;
  logic        acc_smm = 0, acc_wr = 0, hole_wdrop;
  logic [1:0]  route;

  smm_window_ctl dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]  rt;
    logic [31:0] da;
    logic [31:0] hd;
    logic        wd;
    logic [15:0] cf;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic push(input logic [1:0] rt, input logic [31:0] da,
                      input logic [15:0] cf, input string tag);
    exp_t e;
    e.rt = rt; e.da = da; e.cf = cf;
    e.hd = (rt == 2'd3 && !acc_wr) ? 32'hFFFF_FFFF : 32'h0;
    e.wd = (rt == 2'd3) && acc_wr;
    expq.push_back(e); tagq.push_back(tag);
  endtask

  task automatic acc(input logic [31:0] a, input logic smm, input logic wr,
                     input logic [1:0] rt, input logic [31:0] da,
                     input logic [15:0] cf, input string tag);
    @(posedge clk); #1;
    acc_addr = a; acc_smm = smm; acc_wr = wr;
    push(rt, da, cf, tag);
  endtask

  task automatic cfg(input logic [1:0] be, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  always @(negedge clk) begin
    if (expq.size() > 0) begin
      exp_t e;
      string t;
      e = expq.pop_front(); t = tagq.pop_front();
      checks++;
      if (route !== e.rt || dram_addr !== e.da || hole_rdata !== e.hd ||
          hole_wdrop !== e.wd || cfg_rdata !== e.cf) begin
        errors++;
        $display("FAIL %s: got rt=%0d da=%h hd=%h wd=%b cf=%h exp rt=%0d da=%h hd=%h wd=%b cf=%h",
                 t, route, dram_addr, hole_rdata, hole_wdrop, cfg_rdata,
                 e.rt, e.da, e.hd, e.wd, e.cf);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state, R4 closed low window, R5 SMM without global enable
    acc(32'h000A_0000, 0, 0, 2'd2, 32'h000A_0000, 16'h3802, "R1 reset / R4 closed low");
    acc(32'h000A_0000, 1, 0, 2'd2, 32'h000A_0000, 16'h3802, "R5 gen=0 SMM low");
    acc(32'hFEDA_0000, 0, 0, 2'd0, 32'hFEDA_0000, 16'h3802, "R9 high not decoded");
    acc(32'h1234_5678, 0, 0, 2'd0, 32'h1234_5678, 16'h3802, "R9 outside");
    // R2 open + global enable, high enable 0
    cfg(2'b11, 16'h0048);
    acc(32'h000A_0000, 0, 0, 2'd1, 32'h000A_0000, 16'h384A, "R2 R4 open hien=0 low DRAM");
    acc(32'hFEDA_0000, 0, 0, 2'd0, 32'hFEDA_0000, 16'h384A, "R4 open hien=0 high pass");
    acc(32'h000B_FFFF, 1, 0, 2'd1, 32'h000B_FFFF, 16'h384A, "R5 SMM hien=0 low DRAM");
    acc(32'hFEDB_FFFC, 1, 0, 2'd0, 32'hFEDB_FFFC, 16'h384A, "R5 SMM hien=0 high pass");
    acc(32'h000C_0000, 0, 0, 2'd0, 32'h000C_0000, 16'h384A, "R9 just past low");
    // high enable + 1 MB segment
    cfg(2'b10, 16'h8100);
    acc(32'h000A_0000, 0, 0, 2'd2, 32'h000A_0000, 16'hB94A, "R4 open hien=1 low PCI");
    acc(32'hFEDA_1234, 0, 0, 2'd1, 32'h000A_1234, 16'hB94A, "R4 R8 open hien=1 high DRAM");
    acc(32'hFEDA_0000, 1, 0, 2'd1, 32'h000A_0000, 16'hB94A, "R5 R8 SMM hien=1 high");
    acc(32'h000A_0000, 1, 0, 2'd2, 32'h000A_0000, 16'hB94A, "R5 SMM hien=1 low PCI");
    acc(32'h07F0_0002, 0, 0, 2'd3, 32'h07F0_0002, 16'hB94A, "R6 R7 1MB hole read");
    acc(32'h07EF_FFFF, 0, 0, 2'd0, 32'h07EF_FFFF, 16'hB94A, "R7 below segment");
    acc(32'h07FF_FFFC, 0, 1, 2'd3, 32'h07FF_FFFC, 16'hB94A, "R7 hole write dropped");
    acc(32'h07F0_0000, 1, 0, 2'd1, 32'h07F0_0000, 16'hB94A, "R7 SMM segment DRAM");
    acc(32'h0800_0000, 0, 0, 2'd0, 32'h0800_0000, 16'hB94A, "R7 at tolm pass");
    // R6 size codes
    cfg(2'b10, 16'h8300);
    acc(32'h07E0_0000, 0, 0, 2'd3, 32'h07E0_0000, 16'hBB4A, "R6 2MB base");
    acc(32'h07DF_FFFC, 0, 0, 2'd0, 32'h07DF_FFFC, 16'hBB4A, "R6 2MB below");
    cfg(2'b10, 16'h8500);
    acc(32'h0780_0000, 0, 0, 2'd3, 32'h0780_0000, 16'hBD4A, "R6 8MB base");
    acc(32'h077F_FFFC, 0, 0, 2'd0, 32'h077F_FFFC, 16'hBD4A, "R6 8MB below");
    cfg(2'b10, 16'h8700);
    acc(32'h07FF_FFFC, 0, 0, 2'd0, 32'h07FF_FFFC, 16'hBF4A, "R6 code 11 none");
    cfg(2'b10, 16'h8000);
    acc(32'h07FF_FFFC, 0, 0, 2'd0, 32'h07FF_FFFC, 16'hB84A, "R6 enable 0 none");
    // R2 byte enable: only SMRAM byte written, open cleared
    cfg(2'b01, 16'hFF08);
    acc(32'h000A_0000, 0, 0, 2'd2, 32'h000A_0000, 16'hB80A, "R2 be=01 / R4 closed low");
    acc(32'hFEDA_0000, 0, 0, 2'd0, 32'hFEDA_0000, 16'hB80A, "R4 closed high pass");
    acc(32'hFEDA_0010, 1, 0, 2'd1, 32'h000A_0010, 16'hB80A, "R5 closed SMM high DRAM");
    // R10 same-cycle write and access
    @(posedge clk); #1;
    cfg_wr = 1; cfg_be = 2'b01; cfg_wdata = 16'h0048;
    acc_addr = 32'hFEDA_0000; acc_smm = 0; acc_wr = 0;
    push(2'd0, 32'hFEDA_0000, 16'hB80A, "R10 old bytes in write cycle");
    @(posedge clk); #1;
    cfg_wr = 0;
    push(2'd1, 32'h000A_0000, 16'hB84A, "R10 new bytes next cycle");
    // R3 lock with open requested
    cfg(2'b11, 16'h0058);
    acc(32'hFEDA_0000, 0, 0, 2'd0, 32'hFEDA_0000, 16'h381A, "R3 lock forces open 0");
    cfg(2'b11, 16'hFFFF);
    acc(32'h000A_0000, 0, 0, 2'd2, 32'h000A_0000, 16'h381A, "R3 locked write ignored");
    acc(32'h000A_0000, 1, 0, 2'd1, 32'h000A_0000, 16'h381A, "R3 R5 locked SMM low");
    cfg(2'b01, 16'h0000);
    acc(32'h07FF_FFFC, 0, 0, 2'd0, 32'h07FF_FFFC, 16'h381A, "R3 lock sticky");
    // R1 reset clears lock
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    acc(32'h000A_0000, 0, 0, 2'd2, 32'h000A_0000, 16'h3802, "R1 R11 reset after lock");
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule